// File: doc/BRIEF.md
# Drowsy Cache Line Power Controller

This block keeps a low-leakage power state for every line of a small direct-mapped cache. Each line is either awake, meaning powered and readable with no delay, or drowsy, meaning at a reduced supply that keeps its contents but needs a short wake-up before it can be used. The data and tag arrays, the supply switches, and miss handling sit outside the block. It only decides which lines are drowsy, and it tells the requester when an access may go ahead.

A requester presents one access at a time as a line index together with a valid flag. It keeps both steady until it sees the grant. A hit on an awake line is granted in the same cycle. A hit on a drowsy line first holds the requester in a stall for a fixed number of wake-up cycles, then gives a single grant pulse. A window timer counts enabled cycles up to a programmable length, and at the end of each window it puts every line back to sleep. A length of 2000 cycles is a typical setting. Two counters record the number of wake-ups and the running sum of drowsy lines over all cycles, so software or a bench can estimate the leakage saved.

Top module: `drowsy_line_ctrl`

## Requirements
- R1: After reset, every bit of `drowsy_map` is 0 (all lines awake), `stall` and `grant` are low, both counters read 0, and the window count starts from zero.
- R2: A valid request to an awake line, made while no wake-up is in progress, raises `grant` in the same cycle with no stall.
- R3: A valid request to a drowsy line, made while `enable` is high, starts a wake-up. When the wake-up ends, the line's bit in `drowsy_map` reads 0.
- R4: After a drowsy-line request, `stall` is high for exactly WAKE_PENALTY cycles, starting in the next cycle. `grant` pulses in the cycle after the last stall cycle. `stall` and `grant` are never high together.
- R5: The window count advances once per enabled cycle. In the cycle where it reaches `window_len`-1 (a `window_len` of 0 or 1 means every cycle), every bit of `drowsy_map` reads 1 in the next cycle and the count restarts from zero.
- R6: If a window end falls in the final wake-up cycle, the line being woken reads awake in the next cycle while all other lines go drowsy, and the grant is still issued.
- R7: A request that is present during stall cycles or during the grant cycle of a wake-up starts no second wake-up. Each drowsy-line access adds exactly one to `wake_count` and yields exactly one grant.
- R8: `wake_count` adds one in the cycle after each accepted drowsy-line request. `drowsy_cycles` adds, every cycle, the number of 1 bits that `drowsy_map` shows in that cycle.
- R9: While `enable` is low, `stall` stays low, `drowsy_map` reads all zeros from the next cycle on, the window count holds its value, and a valid request is granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global power-saving enable |
| window_len | input | WIN_W | Window length in enabled cycles |
| req_valid | input | 1 | Access request, held until grant |
| req_index | input | IDX_W | Line index of the request |
| drowsy_map | output | NUM_LINES | One bit per line, 1 = drowsy |
| stall | output | 1 | Requester must wait (wake-up in progress) |
| grant | output | 1 | Access may proceed this cycle |
| wake_count | output | CNT_W | Number of drowsy-line wake-ups |
| drowsy_cycles | output | CNT_W | Sum of drowsy lines over all cycles |

## Verification
The assertions assume that the requester keeps `req_valid` and `req_index` unchanged from the request until the grant, and that `req_index` always names an existing line. The stimulus follows this by latching each random request in a hold flag that clears only after a grant has been seen. Enable toggles and window length changes are random, and they may land in the middle of a wake-up. Directed sweeps of the request phase against a short window force a window end to fall in the final wake-up cycle.

// File: rtl/drowsy_pkg.sv
package drowsy_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_WAKE  = 2'd1,
    ACC_GRANT = 2'd2
  } acc_state_e;

  // Final count value of a window; lengths 0 and 1 both end every cycle.
  function automatic logic [31:0] window_last(input logic [31:0] len);
    return (len == 32'd0) ? 32'd0 : len - 32'd1;
  endfunction

endpackage

// File: rtl/drowsy_window_timer.sv
module drowsy_window_timer #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [WIN_W-1:0] window_len,
  output logic             boundary
);
  import drowsy_pkg::*;

  logic [WIN_W-1:0] win_q;
  logic [31:0]      last_w;

  assign last_w   = window_last(32'(window_len));
  assign boundary = enable && (32'(win_q) >= last_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (enable) begin
      win_q <= boundary ? '0 : win_q + WIN_W'(1);
    end
  end

endmodule

// File: rtl/drowsy_access_fsm.sv
module drowsy_access_fsm #(
  parameter int IDX_W   = 4,
  parameter int PENALTY = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_index,
  input  logic             line_drowsy,
  output logic             grant,
  output logic             stall,
  output logic             accept_drowsy,
  output logic             wake_done,
  output logic [IDX_W-1:0] wake_idx
);
  import drowsy_pkg::*;

  localparam int PEN_W = (PENALTY > 1) ? $clog2(PENALTY) : 1;

  acc_state_e       state_q, state_d;
  logic [PEN_W-1:0] pen_q, pen_d;

  always_comb begin
    state_d       = state_q;
    pen_d         = pen_q;
    grant         = 1'b0;
    stall         = 1'b0;
    accept_drowsy = 1'b0;
    wake_done     = 1'b0;
    case (state_q)
      ACC_IDLE: begin
        if (req_valid) begin
          if (!enable || !line_drowsy) begin
            grant = 1'b1;
          end else begin
            accept_drowsy = 1'b1;
            state_d       = ACC_WAKE;
            pen_d         = '0;
          end
        end
      end
      ACC_WAKE: begin
        stall = enable;
        if (!enable || pen_q == PEN_W'(PENALTY - 1)) begin
          wake_done = 1'b1;
          state_d   = ACC_GRANT;
        end else begin
          pen_d = pen_q + PEN_W'(1);
        end
      end
      ACC_GRANT: begin
        grant   = 1'b1;
        state_d = ACC_IDLE;
      end
      default: state_d = ACC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ACC_IDLE;
      pen_q    <= '0;
      wake_idx <= '0;
    end else begin
      state_q <= state_d;
      pen_q   <= pen_d;
      if (accept_drowsy) wake_idx <= req_index;
    end
  end

endmodule

// File: rtl/drowsy_line_array.sv
module drowsy_line_array #(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 boundary,
  input  logic                 wake_done,
  input  logic [IDX_W-1:0]     wake_idx,
  output logic [NUM_LINES-1:0] drowsy_map
);

  logic [NUM_LINES-1:0] map_d;

  always_comb begin
    if (!enable) begin
      map_d = '0;
    end else begin
      map_d = boundary ? '1 : drowsy_map;
      // the line being woken wins over a coinciding window end
      if (wake_done) map_d[wake_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) drowsy_map <= '0;
    else        drowsy_map <= map_d;
  end

endmodule

// File: rtl/drowsy_stats.sv
module drowsy_stats #(
  parameter int NUM_LINES = 16,
  parameter int CNT_W     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept_drowsy,
  input  logic [NUM_LINES-1:0] drowsy_map,
  output logic [CNT_W-1:0]     wake_count,
  output logic [CNT_W-1:0]     drowsy_cycles
);

  function automatic logic [CNT_W-1:0] ones_in(input logic [NUM_LINES-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < NUM_LINES; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wake_count    <= '0;
      drowsy_cycles <= '0;
    end else begin
      wake_count    <= wake_count + CNT_W'(accept_drowsy);
      drowsy_cycles <= drowsy_cycles + ones_in(drowsy_map);
    end
  end

endmodule

// File: rtl/drowsy_line_ctrl.sv
module drowsy_line_ctrl #(
  parameter int NUM_LINES    = 16,
  parameter int WAKE_PENALTY = 1,
  parameter int WIN_W        = 16,
  parameter int CNT_W        = 32,
  localparam int IDX_W       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [WIN_W-1:0]     window_len,
  input  logic                 req_valid,
  input  logic [IDX_W-1:0]     req_index,
  output logic [NUM_LINES-1:0] drowsy_map,
  output logic                 stall,
  output logic                 grant,
  output logic [CNT_W-1:0]     wake_count,
  output logic [CNT_W-1:0]     drowsy_cycles
);

  // named internal events, also observed by the bound checker
  logic             boundary;
  logic             accept_drowsy;
  logic             wake_done;
  logic [IDX_W-1:0] wake_idx;
  logic             line_drowsy;

  assign line_drowsy = drowsy_map[req_index];

  drowsy_window_timer #(.WIN_W(WIN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .window_len(window_len), .boundary(boundary)
  );

  drowsy_access_fsm #(.IDX_W(IDX_W), .PENALTY(WAKE_PENALTY)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .req_valid(req_valid), .req_index(req_index), .line_drowsy(line_drowsy),
    .grant(grant), .stall(stall), .accept_drowsy(accept_drowsy),
    .wake_done(wake_done), .wake_idx(wake_idx)
  );

  drowsy_line_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_lines (
    .clk(clk), .rst_n(rst_n), .enable(enable), .boundary(boundary),
    .wake_done(wake_done), .wake_idx(wake_idx), .drowsy_map(drowsy_map)
  );

  drowsy_stats #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .accept_drowsy(accept_drowsy),
    .drowsy_map(drowsy_map), .wake_count(wake_count),
    .drowsy_cycles(drowsy_cycles)
  );

endmodule

// File: rtl/drowsy_line_ctrl_chk.sv
module drowsy_line_ctrl_chk #(
  parameter int NUM_LINES    = 16,
  parameter int WAKE_PENALTY = 1,
  parameter int CNT_W        = 32,
  parameter int IDX_W        = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable,
  input logic                 stall,
  input logic                 grant,
  input logic [NUM_LINES-1:0] drowsy_map,
  input logic [CNT_W-1:0]     wake_count,
  input logic                 boundary,
  input logic                 accept_drowsy,
  input logic                 wake_done,
  input logic [IDX_W-1:0]     wake_idx
);

  int unsigned stall_run;

  always_ff @(posedge clk) begin
    if (!rst_n)     stall_run <= 0;
    else if (stall) stall_run <= stall_run + 1;
    else            stall_run <= 0;
  end

  AST_STALL_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && grant)); // R4
  AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (stall_run < WAKE_PENALTY)); // R4
  AST_GRANT_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> grant); // R4
  AST_WOKEN_LINE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_done && enable) |=> (drowsy_map[wake_idx] == 1'b0)); // R6
  AST_WINDOW_DROWSES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !wake_done) |=> (&drowsy_map)); // R5
  AST_WAKE_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept_drowsy |=> (wake_count == $past(wake_count) + CNT_W'(1))); // R8
  AST_DISABLED_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !stall); // R9
  AST_DISABLED_ALL_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (drowsy_map == '0)); // R9

endmodule

bind drowsy_line_ctrl drowsy_line_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .WAKE_PENALTY(WAKE_PENALTY),
  .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .stall(stall), .grant(grant),
  .drowsy_map(drowsy_map), .wake_count(wake_count), .boundary(boundary),
  .accept_drowsy(accept_drowsy), .wake_done(wake_done), .wake_idx(wake_idx)
);

// File: tb/drowsy_line_ctrl_bench.sv
`timescale 1ns/1ps
module drowsy_line_ctrl_bench;
  localparam int N  = 16;
  localparam int P  = 3;
  localparam int IW = 4;
  localparam int WW = 16;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [WW-1:0] window_len = 16'd8;
  logic          req_valid = 1'b0;
  logic [IW-1:0] req_index = '0;
  logic [N-1:0]  drowsy_map;
  logic          stall, grant;
  logic [CW-1:0] wake_count, drowsy_cycles;

  always #2.5 clk = ~clk;

  drowsy_line_ctrl #(.NUM_LINES(N), .WAKE_PENALTY(P), .WIN_W(WW), .CNT_W(CW))
  u_drowsy_line_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .window_len(window_len),
    .req_valid(req_valid), .req_index(req_index), .drowsy_map(drowsy_map),
    .stall(stall), .grant(grant), .wake_count(wake_count),
    .drowsy_cycles(drowsy_cycles)
  );

  int checks = 0;
  int errors = 0;

  // requirement-level model: 0 idle, 1 waking, 2 granting
  logic [N-1:0]  m_map = '0;
  int            m_win = 0;
  int            m_st = 0;
  int            m_pen = 0;
  int            m_widx = 0;
  logic [CW-1:0] m_wakes = '0;
  logic [CW-1:0] m_dcyc = '0;
  bit            seen_grant;

  function automatic int ones(input logic [N-1:0] v);
    int n = 0;
    for (int i = 0; i < N; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int end_of_window(input int len);
    if (len < 2) return 0;
    return len - 1;
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one clock cycle: predict, compare mid-cycle, advance the model
  task automatic step(input string tag);
    bit e_grant, e_stall, take, done, bnd;
    logic [N-1:0] nm;
    e_grant = (m_st == 0 && req_valid && (!enable || !m_map[req_index])) || m_st == 2;
    take    = m_st == 0 && req_valid && enable && m_map[req_index];
    e_stall = m_st == 1 && enable;
    done    = m_st == 1 && (!enable || m_pen == P - 1);
    bnd     = enable && m_win >= end_of_window(int'(window_len));
    #1;
    chk(tag, "drowsy_map", longint'(drowsy_map), longint'(m_map));
    chk(tag, "grant", longint'(grant), longint'(e_grant));
    chk(tag, "stall", longint'(stall), longint'(e_stall));
    chk(tag, "wake_count", longint'(wake_count), longint'(m_wakes));
    chk(tag, "drowsy_cycles", longint'(drowsy_cycles), longint'(m_dcyc));
    seen_grant = grant;
    if (!enable) nm = '0;
    else begin
      nm = bnd ? '1 : m_map;
      if (done) nm[m_widx] = 1'b0;
    end
    m_dcyc = m_dcyc + CW'(ones(m_map));
    if (take) begin
      m_wakes = m_wakes + 1;
      m_widx  = int'(req_index);
    end
    case (m_st)
      0: if (take) begin m_st = 1; m_pen = 0; end
      1: if (done) m_st = 2; else m_pen++;
      default: m_st = 0;
    endcase
    if (enable) m_win = bnd ? 0 : m_win + 1;
    m_map = nm;
    @(posedge clk);
    #1;
  endtask

  // hold one request until granted; report wake-ups and grants it caused
  task automatic access(input int idx, input string tag, output int wakes, output int grants);
    int guard = 0;
    logic [CW-1:0] w0;
    w0 = wake_count;
    grants = 0;
    req_valid = 1'b1;
    req_index = IW'(idx);
    do begin
      step(tag);
      if (seen_grant) grants++;
      guard++;
    end while (!seen_grant && guard < 40);
    req_valid = 1'b0;
    wakes = int'(wake_count - w0);
  endtask

  initial begin
    int w, g;
    bit holding;
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    #1;
    rst_n  = 1'b1;
    enable = 1'b1;

    // R1: reset state, window counting from zero
    chk("R1", "drowsy_map after reset", longint'(drowsy_map), 0);
    chk("R1", "wake_count after reset", longint'(wake_count), 0);
    step("R1");
    // R2: awake line granted in the same cycle
    req_valid = 1'b1; req_index = 4'd5;
    step("R2");
    req_valid = 1'b0;
    repeat (8) step("R5");
    chk("R5", "all lines drowsy after first window", longint'(drowsy_map), longint'({N{1'b1}}));

    // R3 R4 R7: drowsy access, single wake and single grant
    window_len = 16'd200;
    access(3, "R4", w, g);
    chk("R7", "wake-ups per drowsy access", w, 1);
    chk("R7", "grants per drowsy access", g, 1);
    chk("R3", "line 3 awake after wake", longint'(drowsy_map[3]), 0);
    access(3, "R2", w, g);
    chk("R2", "no wake on awake line", w, 0);

    // R6: sweep request phase against a short window
    window_len = 16'd6;
    for (int ph = 0; ph < 12; ph++) begin
      repeat (ph % 6) step("R6");
      access((ph * 5) % N, "R6", w, g);
      chk("R6", "grant issued", g, 1);
    end

    // R9: disabled, all awake, immediate grants, timer frozen
    enable = 1'b0;
    step("R9");
    for (int k = 0; k < 6; k++) begin
      req_valid = 1'b1; req_index = IW'(k);
      step("R9");
    end
    req_valid = 1'b0;
    chk("R9", "all awake while disabled", longint'(drowsy_map), 0);
    enable = 1'b1;
    repeat (10) step("R9");

    // R5: lengths 1 and 0 end every cycle, then a 2000-cycle window
    window_len = 16'd1;
    repeat (4) step("R5");
    window_len = 16'd0;
    repeat (4) step("R5");
    enable = 1'b0; step("R5"); enable = 1'b1;
    window_len = 16'd2000;
    repeat (2005) step("R5");

    // R8: random traffic, enable and window changes
    holding = 1'b0;
    window_len = 16'd20;
    for (int c = 0; c < 6000; c++) begin
      if (!holding) begin
        if ($urandom % 3 == 0) begin
          req_valid = 1'b1; req_index = IW'($urandom % N); holding = 1'b1;
        end else req_valid = 1'b0;
      end
      if ($urandom % 150 == 0) enable = ~enable;
      if ($urandom % 400 == 0) window_len = WW'(1 + $urandom % 40);
      step("R8");
      if (holding && seen_grant) begin holding = 1'b0; req_valid = 1'b0; end
    end
    req_valid = 1'b0;
    enable = 1'b1;
    repeat (5) step("R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule